// File: doc/BRIEF.md
# I2C Master Bus-Primitive Sequencer

This block is an I2C bus master that software steers one bus primitive at a time. It does not run whole transactions. Software picks one of seven primitives with a 3-bit operation code in the control register and sets the go bit in the same write. The block then runs that primitive on the open-drain SCL and SDA lines. The primitives are start condition, stop condition, byte transmit, byte receive, ACK transmit, NAK transmit and ACK/NAK sample. While the primitive runs, the go bit reads back as busy. Software polls it before it issues the next primitive.

The bus timing comes from a fixed divider. Every bit slot is four quarter periods of `QTR_CYCLES` clock cycles each. Byte operations use eight slots and all other primitives use one. The block has a small register port: control at address 0, transmit byte at address 1, received byte at address 2 and status at address 3. A `master_en` input tells the block whether the surrounding unit is set up as an I2C master. Clock stretching, arbitration, slave operation and interrupts are not part of the block.

Top module: `i2c_prim_master`

## Requirements
- R1: The control register (address 0) holds the operation code in bits 2:0, which are read/write and reset to 0. Bit 4 reads as busy. Bits 7:5 and bit 3 always read 0. The codes are: 0 start, 1 stop, 2 transmit byte, 3 receive byte, 4 send ACK, 5 send NAK, 6 sample ACK/NAK, 7 reserved.
- R2: A control write with bit 4 set, while `master_en` is high and the block is idle, launches the coded primitive. Busy then reads 1 for exactly 4*QTR_CYCLES*slots clock cycles, starting with the cycle after the write. Slots is 8 for the byte codes and 1 for all other codes.
- R3: A control write with bit 4 clear stores the code and launches nothing. Busy stays 0 and both bus lines stay unchanged.
- R4: While `master_en` is low, a write with bit 4 set launches nothing. The code field is still stored.
- R5: A launch with reserved code 7 completes at once. Busy never reads 1 and neither bus line moves.
- R6: A control write that arrives while busy is ignored. Busy and the running code read back unchanged.
- R7: A start leaves SDA falling while SCL is high. A stop leaves SDA rising while SCL is high and ends with both lines released.
- R8: A byte transmit sends the address-1 byte MSB first. SDA changes only while SCL is low, so no start or stop appears on the bus.
- R9: A byte receive releases SDA, samples it once per SCL high phase with the MSB first, and puts the byte in the address-2 register when it finishes.
- R10: Send ACK drives SDA low for one SCL pulse. Send NAK leaves SDA released (1) for one SCL pulse.
- R11: Sample ACK/NAK releases SDA for one SCL pulse and stores the sampled level in status bit 0 (address 3), where 1 means NAK.
- R12: After reset both lines are released (`scl_oe` and `sda_oe` low), and the control, received-byte and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Unit is configured as I2C master |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of a running primitive. It must be dropped without corrupting the code that is already executing. The stimulus launches a byte transmit, then writes a different code with the go bit set a few cycles later, and reads the control register back before and after the transmit ends. Received data and ACK sampling need a responding device. The bench models one as a pull-down on the shared SDA wire that changes on SCL falling edges. The bench walks a legal bus sequence of start, bytes, acknowledges, a repeated start and a stop.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_STOP  = 3'd1,
        OP_TX    = 3'd2,
        OP_RX    = 3'd3,
        OP_ACK   = 3'd4,
        OP_NAK   = 3'd5,
        OP_RACK  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_TXBYTE = 2'd1;
    localparam logic [1:0] ADDR_RXBYTE = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    localparam int GO_BIT = 4;

    typedef struct packed {
        logic       busy;
        op_e        op;
        logic [2:0] slot;
        logic [1:0] qtr;
        logic [7:0] sh;
        logic       scl_lo;
        logic       sda_lo;
        logic [7:0] rx;
        logic       nak;
    } eng_t;

endpackage

// File: rtl/i2c_prim_tick.sv
module i2c_prim_tick #(
    parameter int QTR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/i2c_prim_regs.sv
module i2c_prim_regs
    import i2c_prim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       busy,
    input  logic [7:0] rx_byte,
    input  logic       nak,
    output logic [7:0] reg_rdata,
    output logic [2:0] code,
    output logic [7:0] tx_byte,
    output logic       launch,
    output op_e        launch_op
);
    typedef struct packed {
        logic [2:0] code;
        logic [7:0] tx;
    } regs_t;

    regs_t r_d, r_q;
    logic  ctl_wr;

    always_comb begin
        r_d       = r_q;
        ctl_wr    = reg_wr && (reg_addr == ADDR_CTRL) && !busy;
        launch    = ctl_wr && master_en && reg_wdata[GO_BIT]
                    && (reg_wdata[2:0] != OP_RSVD);
        launch_op = op_e'(reg_wdata[2:0]);
        if (ctl_wr) begin
            r_d.code = reg_wdata[2:0];
        end
        if (reg_wr && (reg_addr == ADDR_TXBYTE)) begin
            r_d.tx = reg_wdata;
        end
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {3'b000, busy, 1'b0, r_q.code};
            ADDR_TXBYTE: reg_rdata = r_q.tx;
            ADDR_RXBYTE: reg_rdata = rx_byte;
            default:     reg_rdata = {7'd0, nak};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code    = r_q.code;
    assign tx_byte = r_q.tx;
endmodule

// File: rtl/i2c_prim_engine.sv
module i2c_prim_engine
    import i2c_prim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  op_e        launch_op,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       sda_in,
    output logic       busy,
    output op_e        run_op,
    output logic       scl_lo,
    output logic       sda_lo,
    output logic [7:0] rx_byte,
    output logic       nak
);
    eng_t       e_d, e_q;
    logic [2:0] last_slot;

    always_comb begin
        e_d       = e_q;
        last_slot = ((e_q.op == OP_TX) || (e_q.op == OP_RX)) ? 3'd7 : 3'd0;
        if (!e_q.busy) begin
            if (launch) begin
                e_d.busy = 1'b1;
                e_d.op   = launch_op;
                e_d.slot = '0;
                e_d.qtr  = '0;
                e_d.sh   = tx_byte;
            end
        end else if (tick) begin
            e_d.qtr = e_q.qtr + 2'd1;
            case (e_q.qtr)
                2'd0: begin
                    case (e_q.op)
                        OP_START: e_d.sda_lo = 1'b0;
                        OP_STOP:  begin e_d.scl_lo = 1'b1; e_d.sda_lo = 1'b1; end
                        OP_TX:    begin e_d.scl_lo = 1'b1; e_d.sda_lo = ~e_q.sh[7]; end
                        OP_ACK:   begin e_d.scl_lo = 1'b1; e_d.sda_lo = 1'b1; end
                        default:  begin e_d.scl_lo = 1'b1; e_d.sda_lo = 1'b0; end
                    endcase
                end
                2'd1: begin
                    e_d.scl_lo = 1'b0;
                end
                2'd2: begin
                    case (e_q.op)
                        OP_START: e_d.sda_lo = 1'b1;
                        OP_STOP:  e_d.sda_lo = 1'b0;
                        OP_TX,
                        OP_RX:    e_d.sh = {e_q.sh[6:0], sda_in};
                        OP_RACK:  e_d.nak = sda_in;
                        default:  ;
                    endcase
                end
                default: begin
                    if (e_q.op != OP_STOP) begin
                        e_d.scl_lo = 1'b1;
                    end
                    if (e_q.slot == last_slot) begin
                        e_d.busy = 1'b0;
                        if (e_q.op == OP_RX) begin
                            e_d.rx = e_q.sh;
                        end
                    end else begin
                        e_d.slot = e_q.slot + 3'd1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy    = e_q.busy;
    assign run_op  = e_q.op;
    assign scl_lo  = e_q.scl_lo;
    assign sda_lo  = e_q.sda_lo;
    assign rx_byte = e_q.rx;
    assign nak     = e_q.nak;
endmodule

// File: rtl/i2c_prim_master.sv
module i2c_prim_master
    import i2c_prim_pkg::*;
#(
    parameter int QTR_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master_en,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic       busy;
    logic       tick;
    logic       launch;
    op_e        launch_op;
    op_e        run_op;
    logic [2:0] code;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       nak;

    generate
        if (SYNC_STAGES > 1) begin : g_sync_chain
            always_comb sync_d = {sync_q[SYNC_STAGES-2:0], sda_in};
        end else begin : g_sync_single
            always_comb sync_d = sda_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    i2c_prim_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .rx_byte   (rx_byte),
        .nak       (nak),
        .reg_rdata (reg_rdata),
        .code      (code),
        .tx_byte   (tx_byte),
        .launch    (launch),
        .launch_op (launch_op)
    );

    i2c_prim_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    i2c_prim_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_op (launch_op),
        .tx_byte   (tx_byte),
        .tick      (tick),
        .sda_in    (sync_q[SYNC_STAGES-1]),
        .busy      (busy),
        .run_op    (run_op),
        .scl_lo    (scl_oe),
        .sda_lo    (sda_oe),
        .rx_byte   (rx_byte),
        .nak       (nak)
    );
endmodule

// File: rtl/i2c_prim_master_chk.sv
module i2c_prim_master_chk
    import i2c_prim_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       master_en,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       busy,
    input logic [2:0] code,
    input op_e        run_op,
    input logic       scl_oe,
    input logic       sda_oe
);
    logic ctl_go;
    assign ctl_go = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[GO_BIT];

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && master_en && !busy && (reg_wdata[2:0] != 3'd7)) |=> busy);

    assert_no_launch_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && !master_en && !busy) |=> !busy);

    assert_reserved_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && !busy && (reg_wdata[2:0] == 3'd7)) |=> !busy);

    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_CTRL) && busy) |=> (code == $past(code)));

    assert_idle_lines_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

    assert_data_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ((run_op == OP_TX) || (run_op == OP_RX))
         && (scl_oe == 1'b0)) |-> $stable(sda_oe));
endmodule

bind i2c_prim_master i2c_prim_master_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .code      (code),
    .run_op    (run_op),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
);

// File: tb/i2c_prim_master_tb_top.sv
`timescale 1ns/1ps
module i2c_prim_master_tb_top;
    localparam int QTR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       scl_bus, sda_bus, slave_pull;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int starts = 0, stops = 0, neg_cnt = 0;
    logic [7:0] mon_sh = 8'd0;
    int   smode = 0, sbase = 0;
    logic [7:0] sbyte = 8'd0;
    logic snak = 1'b0;

    always #4 clk = ~clk;

    assign scl_bus = !scl_oe;
    assign sda_bus = !(sda_oe || slave_pull);

    always @* begin
        int idx;
        idx = neg_cnt - sbase;
        if (smode == 1)      slave_pull = (idx < 8) ? !sbyte[7 - (idx % 8)] : 1'b0;
        else if (smode == 2) slave_pull = !snak;
        else                 slave_pull = 1'b0;
    end

    i2c_prim_master #(.QTR_CYCLES(QTR)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sda_in    (sda_bus),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    always @(negedge sda_bus) if (scl_bus === 1'b1) starts++;
    always @(posedge sda_bus) if (scl_bus === 1'b1) stops++;
    always @(posedge scl_bus) mon_sh <= {mon_sh[6:0], sda_bus};
    always @(negedge scl_bus) neg_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Launch a primitive and count cycles with busy set (R2).
    task automatic run_op(input logic [2:0] op, output int n);
        @(negedge clk);
        reg_addr = 2'd0; reg_wdata = {3'b000, 1'b1, 1'b0, op}; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
        n = 0;
        while (reg_rdata[4] && n < 4000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    // {op, tx byte, slave byte / nak, expected}
    localparam logic [26:0] VEC [0:11] = '{
        {3'd0, 8'h00, 8'h00, 8'h01},
        {3'd2, 8'hA5, 8'h00, 8'hA5},
        {3'd6, 8'h00, 8'h00, 8'h00},
        {3'd2, 8'h3C, 8'h00, 8'h3C},
        {3'd6, 8'h00, 8'h01, 8'h01},
        {3'd0, 8'h00, 8'h00, 8'h01},
        {3'd2, 8'h81, 8'h00, 8'h81},
        {3'd3, 8'h00, 8'h5A, 8'h5A},
        {3'd4, 8'h00, 8'h00, 8'h00},
        {3'd3, 8'h00, 8'hC3, 8'hC3},
        {3'd5, 8'h00, 8'h00, 8'h01},
        {3'd1, 8'h00, 8'h00, 8'h01}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, st0, sp0;
        logic o_scl, o_sda;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        chk("R12 scl_oe", scl_oe, 0);
        chk("R12 sda_oe", sda_oe, 0);
        rd(2'd0, v); chk("R12 ctrl", v, 8'h00);
        rd(2'd2, v); chk("R12 rx", v, 8'h00);
        rd(2'd3, v); chk("R12 status", v, 8'h00);

        // R4 and R1: disabled master, reserved bits read 0
        master_en = 1'b0;
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk("R4 R1 ctrl readback", v, 8'h07);
        repeat (20) @(negedge clk);
        chk("R4 lines idle", {scl_oe, sda_oe}, 2'b00);
        master_en = 1'b1;

        // R3: go bit clear
        wr(2'd0, 8'h06);
        rd(2'd0, v); chk("R3 code stored no busy", v, 8'h06);
        repeat (20) @(negedge clk);
        chk("R3 lines idle", {scl_oe, sda_oe}, 2'b00);

        // R5: reserved code
        run_op(3'd7, n); chk("R5 busy cycles", n, 0);
        rd(2'd0, v); chk("R5 ctrl", v, 8'h07);
        repeat (20) @(negedge clk);
        chk("R5 lines idle", {scl_oe, sda_oe}, 2'b00);

        // Table walk over a legal bus sequence
        for (int i = 0; i < 12; i++) begin
            logic [2:0] op;
            logic [7:0] d, s, e;
            {op, d, s, e} = VEC[i];
            if (op == 3'd2) wr(2'd1, d);
            if (op == 3'd3) begin sbyte = s; sbase = neg_cnt; smode = 1; end
            if (op == 3'd6) begin snak = s[0]; smode = 2; end
            st0 = starts; sp0 = stops;
            run_op(op, n);
            smode = 0;
            chk("R2 busy cycles", n, ((op == 3'd2) || (op == 3'd3)) ? 4*QTR*8 : 4*QTR);
            case (op)
                3'd0: chk("R7 start seen", starts - st0, e);
                3'd1: begin
                    chk("R7 stop seen", stops - sp0, e);
                    chk("R7 lines released", {scl_oe, sda_oe}, 2'b00);
                end
                3'd2: begin
                    chk("R8 byte on bus", mon_sh, e);
                    chk("R8 no start/stop", (starts - st0) + (stops - sp0), 0);
                end
                3'd3: begin rd(2'd2, v); chk("R9 rx byte", v, e); end
                3'd6: begin rd(2'd3, v); chk("R11 nak status", v, e); end
                default: chk("R10 ack/nak bit", mon_sh[0], e[0]);
            endcase
        end

        // R6: control write during a running byte transmit
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h12);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h11);
        rd(2'd0, v); chk("R6 busy keeps code", v, 8'h12);
        o_scl = scl_oe; o_sda = sda_oe;
        n = 0;
        while (reg_rdata[4] && n < 4000) begin n++; @(negedge clk); #1; end
        rd(2'd0, v); chk("R6 after finish", v, 8'h02);
        chk("R6 byte unaffected", mon_sh, 8'h55);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule